// File: doc/BRIEF.md
# Byte Arithmetic/Logic Unit with Condition Flags

A purely combinational datapath unit for an 8-bit processor core. Each cycle it takes an operation code, a left and a right operand, the high byte of a register pair and the live condition-flag byte. It returns a result byte, a high result byte and the next flag byte, which the surrounding core writes back. Register storage, program flow and multi-cycle sequencing stay outside the unit.

It covers byte add and subtract (with and without carry-in), compare, negate, ones' complement, bitwise AND/OR/XOR, increment, decrement, the left and right shifts, rotates through carry, nibble exchange, and a 16-bit add or subtract of a small unsigned constant on a register pair. Two further operations set or clear a single flag bit. Each operation rewrites only its own set of flags and copies every other flag bit through unchanged. The sign flag always follows N xor V whenever either of those two is rewritten. That makes signed comparisons after a subtract correct.

Top module: `alu8_core`

## Requirements
- R1: The flag byte holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. I and T leave the unit exactly as they entered, except under the set/clear-flag operations (R13). A flag bit outside an operation's affected set is copied from `sreg_i`.
- R2: ADD (code 0) and ADC (code 1, adds C) return the low byte of lhs+rhs(+C). C is the carry out of bit 7 and H is the carry out of bit 3. V is two's-complement overflow. N is bit 7 of the result and Z is set when the result is zero. These five flags and S are rewritten.
- R3: SUB (2), SBC (3, also subtracts C), CP (4), CPC (5, also subtracts C) and NEG (6, computes 0-lhs) return the low byte of the difference. C is the borrow out of bit 7, H is the borrow out of bit 3, V is signed overflow, and N and Z follow the result. H, S, V, N, Z and C are rewritten.
- R4: Under SBC (3) and CPC (5), Z is set only if the result is zero and Z was already set in `sreg_i`, so a zero result cannot set a cleared Z.
- R5: AND (7), OR (8) and XOR (9) of lhs and rhs clear V. They set N and Z from the result and leave C and H unchanged.
- R6: COM (10) returns 0xFF-lhs with C=1 and V=0. NEG (6) gives C=1 exactly when the result is non-zero and V=1 exactly when the result is 0x80.
- R7: INC (11) and DEC (12) change lhs by one. V is set only for INC of 0x7F and DEC of 0x80. C and H are unchanged.
- R8: LSR (13) shifts a zero into bit 7. ROR (14) shifts the incoming C into bit 7. ASR (15) keeps bit 7. All three put the old bit 0 into C, set V = N xor C, and leave H unchanged.
- R9: LSL (16) shifts a zero into bit 0. ROL (17) shifts the incoming C into bit 0. Both put the old bit 7 into C, set V = N xor C, and leave H unchanged.
- R10: SWAP (18) exchanges the two nibbles of lhs and leaves the whole flag byte unchanged.
- R11: ADIW (19) and SBIW (20) add or subtract the constant rhs[5:0] to or from the 16-bit value {pair_hi_i, lhs_i}. The 16-bit result comes out as {result_hi_o, result_o}. C is the carry or borrow out of bit 15, V is signed overflow, N is bit 15 and Z marks a zero result. Z, C, N, V and S are rewritten and H is unchanged.
- R12: Whenever an operation rewrites N or V, the output S equals N xor V of the output flags.
- R13: BSET (21) sets and BCLR (22) clears flag bit rhs[2:0]. No other flag changes and result_o equals lhs.
- R14: Codes 23 to 31 pass lhs to result_o and `sreg_i` to `sreg_o` unchanged. For every operation other than ADIW/SBIW, result_hi_o equals pair_hi_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code_i | input | 5 | Operation code |
| lhs_i | input | 8 | Left operand; low byte of the pair for word operations |
| rhs_i | input | 8 | Right operand, word constant (low 6 bits) or flag index (low 3 bits) |
| pair_hi_i | input | 8 | High byte of the register pair |
| sreg_i | input | 8 | Current flag byte |
| result_o | output | 8 | Result byte |
| result_hi_o | output | 8 | High result byte for word operations, else pair_hi_i |
| sreg_o | output | 8 | Next flag byte |

## Verification
The bench builds the unit with its defaults: an 8-bit data width and a 6-bit word constant. At 8 bits every operand value and both nibble boundaries are reachable with directed vectors. The 6-bit constant lets a 16-bit pair cross 0xFFFF, 0x0000 and the 0x7FFF/0x8000 sign boundary in one step. Random operands run against random incoming flag bytes, so the carry-in, the stale Z used by SBC/CPC and the deliberately inconsistent S inputs are all covered for every code.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_NEG  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_COM  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_LSR  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
    OP_LSL  = 5'd16, OP_ROL  = 5'd17, OP_SWAP = 5'd18, OP_ADIW = 5'd19,
    OP_SBIW = 5'd20, OP_BSET = 5'd21, OP_BCLR = 5'd22
  } alu_op_e;

  // Flags each operation is allowed to rewrite (bit set = rewritten).
  function automatic logic [7:0] flag_mask(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG:
        flag_mask = 8'h3F;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
        flag_mask = 8'h1E;
      OP_COM, OP_LSR, OP_ROR, OP_ASR, OP_LSL, OP_ROL, OP_ADIW, OP_SBIW:
        flag_mask = 8'h1F;
      default:
        flag_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W  = 8,
  parameter int HB = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         half_o,
  output logic         ovf_o
);

  function automatic logic [W:0] wide_add(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [HB+1:0] low_add(logic [HB:0] x, logic [HB:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{(HB+1){1'b0}}, ci};
  endfunction

  logic [W-1:0]  b_eff;
  logic          ci_eff;
  logic [W:0]    full;
  logic [HB+1:0] nib;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    ci_eff = cin_i ^ sub_i;
    full   = wide_add(a_i, b_eff, ci_eff);
    nib    = low_add(a_i[HB:0], b_eff[HB:0], ci_eff);
    sum_o  = full[W-1:0];
    cout_o = full[W] ^ sub_i;
    half_o = nib[HB+1] ^ sub_i;
    ovf_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         lsb_o
);

  localparam int HALF = W / 2;

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~a_i;
      OP_LSR:  res_o = {1'b0, a_i[W-1:1]};
      OP_ROR:  res_o = {cin_i, a_i[W-1:1]};
      OP_ASR:  res_o = {a_i[W-1], a_i[W-1:1]};
      OP_SWAP: res_o = {a_i[HALF-1:0], a_i[W-1:HALF]};
      default: res_o = a_i;
    endcase
    lsb_o = a_i[0];
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMM_W = 6
) (
  input  logic [4:0]    op_code_i,
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  input  logic [DW-1:0] pair_hi_i,
  input  logic [7:0]    sreg_i,
  output logic [DW-1:0] result_o,
  output logic [DW-1:0] result_hi_o,
  output logic [7:0]    sreg_o
);

  localparam int HB = DW / 2 - 1;
  localparam int WW = 2 * DW;

  alu_op_e op;
  assign op = alu_op_e'(op_code_i);

  // Operation classes, brought out for the assertions below.
  logic is_arith, is_logic, is_shr, is_word, is_flagop, z_sticky, nv_updated;
  logic [7:0] mask;
  assign is_arith   = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
                                  OP_NEG, OP_INC, OP_DEC, OP_LSL, OP_ROL});
  assign is_logic   = (op inside {OP_AND, OP_OR, OP_XOR});
  assign is_shr     = (op inside {OP_LSR, OP_ROR, OP_ASR});
  assign is_word    = (op inside {OP_ADIW, OP_SBIW});
  assign is_flagop  = (op inside {OP_BSET, OP_BCLR});
  assign z_sticky   = (op inside {OP_SBC, OP_CPC});
  assign mask       = flag_mask(op);
  assign nv_updated = mask[FLAG_N] | mask[FLAG_V];

  // Byte adder operand selection.
  logic [DW-1:0] add_a, add_b, add_sum;
  logic          add_ci, add_sub, add_c, add_h, add_v;

  always_comb begin
    add_a   = lhs_i;
    add_b   = rhs_i;
    add_ci  = 1'b0;
    add_sub = 1'b0;
    case (op)
      OP_ADC:        add_ci = sreg_i[FLAG_C];
      OP_SUB, OP_CP: add_sub = 1'b1;
      OP_SBC, OP_CPC: begin add_sub = 1'b1; add_ci = sreg_i[FLAG_C]; end
      OP_NEG: begin add_a = '0; add_b = lhs_i; add_sub = 1'b1; end
      OP_INC:  add_b = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin add_b = {{(DW-1){1'b0}}, 1'b1}; add_sub = 1'b1; end
      OP_LSL:  add_b = lhs_i;
      OP_ROL: begin add_b = lhs_i; add_ci = sreg_i[FLAG_C]; end
      default: ;
    endcase
  end

  alu8_adder #(.W(DW), .HB(HB)) u_byte_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_ci), .sub_i(add_sub),
    .sum_o(add_sum), .cout_o(add_c), .half_o(add_h), .ovf_o(add_v)
  );

  // Register-pair adder for the word operations.
  logic [WW-1:0] w_sum;
  logic          w_c, w_h, w_v;

  alu8_adder #(.W(WW), .HB(HB)) u_word_add (
    .a_i({pair_hi_i, lhs_i}),
    .b_i({{(WW-IMM_W){1'b0}}, rhs_i[IMM_W-1:0]}),
    .cin_i(1'b0), .sub_i(op == OP_SBIW),
    .sum_o(w_sum), .cout_o(w_c), .half_o(w_h), .ovf_o(w_v)
  );

  logic [DW-1:0] bit_res;
  logic          bit_lsb;

  alu8_bitops #(.W(DW)) u_bitops (
    .op_i(op), .a_i(lhs_i), .b_i(rhs_i), .cin_i(sreg_i[FLAG_C]),
    .res_o(bit_res), .lsb_o(bit_lsb)
  );

  // Candidate flags, then merge through the per-operation mask.
  logic [7:0]    cand;
  logic [DW-1:0] res;
  logic [7:0]    sel_bit;

  always_comb begin
    cand = sreg_i;
    res  = lhs_i;
    if (is_arith) begin
      res = add_sum;
      cand[FLAG_C] = add_c;
      cand[FLAG_H] = add_h;
      cand[FLAG_V] = add_v;
    end else if (is_logic || op == OP_SWAP) begin
      res = bit_res;
      cand[FLAG_V] = 1'b0;
    end else if (op == OP_COM) begin
      res = bit_res;
      cand[FLAG_C] = 1'b1;
      cand[FLAG_V] = 1'b0;
    end else if (is_shr) begin
      res = bit_res;
      cand[FLAG_C] = bit_lsb;
      cand[FLAG_V] = bit_res[DW-1] ^ bit_lsb;
    end else if (is_word) begin
      res = w_sum[DW-1:0];
      cand[FLAG_C] = w_c;
      cand[FLAG_V] = w_v;
    end
    if (is_word) begin
      cand[FLAG_N] = w_sum[WW-1];
      cand[FLAG_Z] = (w_sum == '0);
    end else begin
      cand[FLAG_N] = res[DW-1];
      cand[FLAG_Z] = (res == '0) && (!z_sticky || sreg_i[FLAG_Z]);
    end
    cand[FLAG_S] = cand[FLAG_N] ^ cand[FLAG_V];

    sel_bit = 8'b1 << rhs_i[2:0];
    if (op == OP_BSET)      sreg_o = sreg_i | sel_bit;
    else if (op == OP_BCLR) sreg_o = sreg_i & ~sel_bit;
    else                    sreg_o = (sreg_i & ~mask) | (cand & mask);

    result_o    = res;
    result_hi_o = is_word ? w_sum[WW-1:DW] : pair_hi_i;
  end

  // Checks on the merged flag byte against the incoming one.
  always_comb begin
    if (!$isunknown({op_code_i, lhs_i, rhs_i, pair_hi_i, sreg_i})) begin
      if (nv_updated) begin
        assert_sign_tracks_R12: assert (sreg_o[FLAG_S] == (sreg_o[FLAG_N] ^ sreg_o[FLAG_V]))
          else $error("S differs from N^V");
      end
      if (!is_flagop) begin
        assert_it_kept_R1: assert (sreg_o[FLAG_I:FLAG_T] == sreg_i[FLAG_I:FLAG_T])
          else $error("I/T changed");
      end
      if (z_sticky && !sreg_i[FLAG_Z]) begin
        assert_z_sticky_R4: assert (!sreg_o[FLAG_Z]) else $error("Z set from clear");
      end
      if (is_logic) begin
        assert_logic_flags_R5: assert (sreg_o[FLAG_C] == sreg_i[FLAG_C] && !sreg_o[FLAG_V])
          else $error("logic op C/V wrong");
      end
      if (op == OP_SWAP) begin
        assert_swap_flags_R10: assert (sreg_o == sreg_i) else $error("swap touched flags");
      end
      if (op == OP_COM) begin
        assert_com_carry_R6: assert (sreg_o[FLAG_C] && ((result_o ^ lhs_i) == '1))
          else $error("complement wrong");
      end
      if (is_word) begin
        assert_word_known_R11: assert (!$isunknown({w_sum, w_c, w_h, w_v}))
          else $error("word adder unknown");
      end
    end
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] op_code;
  logic [7:0] lhs, rhs, pair_hi, sreg_in;
  logic [7:0] result, result_hi, sreg_out;

  alu8_core dut (
    .op_code_i(op_code), .lhs_i(lhs), .rhs_i(rhs), .pair_hi_i(pair_hi),
    .sreg_i(sreg_in), .result_o(result), .result_hi_o(result_hi), .sreg_o(sreg_out)
  );

  int tests = 0;
  int fails = 0;

  // Reference model: returns {hi, result, flags}.
  function automatic logic [23:0] model(int op, int a, int b, int hi, logic [7:0] s);
    int r, rh, x, y, ci, t, p, rw;
    bit c, h, v, n, z, arith;
    logic [7:0] ns;
    ns = s; r = a; rh = hi; arith = 0;
    c = s[0]; h = s[5]; v = s[3];
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(s[0]) : 0;
        t = a + b + ci; r = t & 255; c = t > 255;
        h = ((a & 15) + (b & 15) + ci) > 15;
        v = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
        arith = 1;
      end
      2, 3, 4, 5, 6: begin
        x = (op == 6) ? 0 : a;
        y = (op == 6) ? a : b;
        ci = (op == 3 || op == 5) ? int'(s[0]) : 0;
        t = x - y - ci; r = t & 255; c = t < 0;
        h = ((x & 15) - (y & 15) - ci) < 0;
        v = ((x >= 128) != (y >= 128)) && ((r >= 128) != (x >= 128));
        arith = 1;
      end
      7: begin r = a & b; v = 0; end
      8: begin r = a | b; v = 0; end
      9: begin r = a ^ b; v = 0; end
      10: begin r = 255 - a; c = 1; v = 0; end
      11: begin r = (a + 1) & 255; v = (a == 127); end
      12: begin r = (a + 255) & 255; v = (a == 128); end
      13, 14, 15: begin
        r = a >> 1;
        if (op == 14) r = r | (int'(s[0]) << 7);
        if (op == 15) r = r | (a & 128);
        c = a[0]; v = (r >= 128) ^ c;
      end
      16, 17: begin
        r = (a << 1) & 255;
        if (op == 17) r = r | int'(s[0]);
        c = (a >= 128); v = (r >= 128) ^ c;
      end
      18: r = ((a & 15) << 4) | (a >> 4);
      19, 20: begin
        p = hi * 256 + a;
        t = (op == 19) ? p + (b & 63) : p - (b & 63);
        rw = t & 65535; c = (op == 19) ? (t > 65535) : (t < 0);
        v = (op == 19) ? (p < 32768 && rw >= 32768) : (p >= 32768 && rw < 32768);
        r = rw & 255; rh = rw >> 8;
      end
      21: ns[b & 7] = 1'b1;
      22: ns[b & 7] = 1'b0;
      default: ;
    endcase
    if (op == 19 || op == 20) begin
      n = (rh >= 128); z = (rh == 0) && (r == 0);
    end else begin
      n = (r >= 128);
      z = (r == 0) && ((op != 3 && op != 5) || s[1]);
    end
    if (op <= 17 || op == 19 || op == 20) begin
      ns[3] = v; ns[2] = n; ns[1] = z; ns[4] = n ^ v;
      if (!(op >= 7 && op <= 9) && op != 11 && op != 12) ns[0] = c;
      if (arith) ns[5] = h;
    end
    model = {rh[7:0], r[7:0], ns};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1: tag_of = "R2 R12";
      2, 4: tag_of = "R3 R12";
      3, 5: tag_of = "R3 R4";
      6: tag_of = "R3 R6";
      7, 8, 9: tag_of = "R5";
      10: tag_of = "R6";
      11, 12: tag_of = "R7";
      13, 14, 15: tag_of = "R8";
      16, 17: tag_of = "R9";
      18: tag_of = "R10";
      19, 20: tag_of = "R11";
      21, 22: tag_of = "R13 R1";
      default: tag_of = "R14 R1";
    endcase
  endfunction

  task automatic apply(int op, logic [7:0] a, logic [7:0] b, logic [7:0] hi, logic [7:0] s);
    logic [23:0] exp_v, got;
    @(negedge clk);
    op_code = op[4:0]; lhs = a; rhs = b; pair_hi = hi; sreg_in = s;
    #1;
    exp_v = model(op, a, b, hi, s);
    got = {result_hi, result, sreg_out};
    tests++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h hi=%h s=%h actual=%h expected=%h",
               tag_of(op), op, a, b, hi, s, got, exp_v);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    op_code = 5'd31; lhs = 8'h00; rhs = 8'h00; pair_hi = 8'h00; sreg_in = 8'h00;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: unused code passes everything through (R14, R1).
    apply(31, 8'hA5, 8'h3C, 8'h77, 8'hC3);
    apply(23, 8'h00, 8'hFF, 8'h01, 8'hFF);
    // Directed corners.
    apply(0, 8'h7F, 8'h01, 8'h00, 8'h00);   // R2 overflow and half carry
    apply(0, 8'hFF, 8'h01, 8'h00, 8'h00);   // R2 carry, zero
    apply(1, 8'hFF, 8'h00, 8'h00, 8'h01);   // R2 carry-in wraps
    apply(2, 8'h00, 8'h01, 8'h00, 8'h00);   // R3 borrow
    apply(2, 8'h80, 8'h01, 8'h00, 8'h00);   // R3 signed overflow
    apply(3, 8'h10, 8'h10, 8'h00, 8'h00);   // R4 zero result, Z was clear
    apply(5, 8'h10, 8'h10, 8'h00, 8'h02);   // R4 zero result, Z was set
    apply(5, 8'h10, 8'h0F, 8'h00, 8'h03);   // R4 carry-in makes zero
    apply(6, 8'h80, 8'h00, 8'h00, 8'h00);   // R6 negate 0x80
    apply(6, 8'h00, 8'h00, 8'h00, 8'h3F);   // R6 negate zero
    apply(10, 8'h00, 8'h00, 8'h00, 8'h00);  // R6 complement
    apply(7, 8'hF0, 8'h0F, 8'h00, 8'h09);   // R5 zero, V cleared, C kept
    apply(11, 8'h7F, 8'h00, 8'h00, 8'h21);  // R7 overflow, C and H kept
    apply(12, 8'h80, 8'h00, 8'h00, 8'h20);  // R7 overflow
    apply(12, 8'h00, 8'h00, 8'h00, 8'h01);  // R7 wrap
    apply(14, 8'h01, 8'h00, 8'h00, 8'h01);  // R8 rotate carry in and out
    apply(15, 8'h81, 8'h00, 8'h00, 8'h00);  // R8 sign kept
    apply(13, 8'h01, 8'h00, 8'h00, 8'h00);  // R8 zero result, C set
    apply(17, 8'h80, 8'h00, 8'h00, 8'h01);  // R9 rotate left
    apply(16, 8'h40, 8'h00, 8'h00, 8'h20);  // R9 V = N^C, H kept
    apply(18, 8'h3C, 8'h00, 8'h00, 8'hFF);  // R10 no flags touched
    apply(19, 8'hFF, 8'h01, 8'hFF, 8'h00);  // R11 pair wraps to zero
    apply(19, 8'hFF, 8'h3F, 8'h7F, 8'h00);  // R11 signed overflow
    apply(20, 8'h00, 8'h01, 8'h00, 8'h20);  // R11 borrow, H kept
    apply(20, 8'h00, 8'hFF, 8'h80, 8'h00);  // R11 overflow, only 6 bits used
    apply(21, 8'h55, 8'h07, 8'h00, 8'h00);  // R13 set I
    apply(22, 8'h55, 8'h08, 8'h00, 8'hFF);  // R13 clear C (index wraps)
    // Random sweep over every code (R12 covered by the reference flags).
    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 150; i++) begin
        apply(op, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule